// File: doc/BRIEF.md
# Frame-Assembled Write Data Buffer

This block sits on the downstream side of a serial memory link, after the frame decoder. Write data does not arrive in the same frames as write commands. The decoder hands the buffer one 72-bit slice of write data per frame. Four such slices, taken in arrival order, make up one burst entry. A write command comes later and on its own. It claims the oldest complete entry, and the block then plays that entry out toward the DRAM side as four beats on consecutive cycles.

The link delivers data more slowly than the DRAM consumes it, so whole bursts are gathered before anything leaves. An entry holding fewer than four slices cannot be drained. It keeps filling until its fourth slice lands. The block counts complete entries that no command has claimed yet and reports that count. It also raises a one-cycle flag in two cases: a slice is dropped because every entry slot is in use, or a command finds no complete entry to claim.

The depth in entries, the beats per entry and the beat width are parameters. Depth and beats must be powers of two.

Top module: `wbuf_burst_buffer`

## Requirements
- R1: After reset `burst_vld_o`, `burst_last_o`, `overflow_o` and `underflow_o` are 0 and `ready_cnt_o` is 0.
- R2: Every fourth accepted slice completes an entry, and `ready_cnt_o` rises by one in the cycle after the clock edge that takes that slice. An entry with one to three slices leaves `ready_cnt_o` unchanged.
- R3: A command sampled while `ready_cnt_o` is nonzero lowers `ready_cnt_o` by one in the next cycle. Two cycles after the command, `burst_vld_o` goes high for exactly four consecutive cycles. `burst_data_o` presents the entry's slices in arrival order, and `burst_last_o` is 1 only on the fourth beat.
- R4: A command sampled while `ready_cnt_o` is 0 makes `underflow_o` 1 for one cycle and issues no burst. A partly filled entry is not disturbed: once it gets its remaining slices, it drains with all four slices intact.
- R5: A slice that would open a new entry while all DEPTH slots are occupied makes `overflow_o` 1 for one cycle and is discarded. A slot counts as occupied if it is complete, claimed, draining or partly filled. The discarded slice never appears in any later burst.
- R6: Entries drain in the order in which they were completed.
- R7: Commands that arrive while a burst is in progress are queued and served in turn, with exactly one idle cycle between consecutive bursts.
- R8: A slot becomes free after the last beat of its burst. Slices offered after that are accepted into a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_frame_vld_i | input | 1 | One write-data slice is present this cycle |
| wr_frame_data_i | input | BEAT_W (72) | Write-data slice |
| wr_cmd_i | input | 1 | Write command strobe, claims one complete entry |
| burst_vld_o | output | 1 | Burst beat valid |
| burst_last_o | output | 1 | Fourth (final) beat of the burst |
| burst_data_o | output | BEAT_W (72) | Burst beat data |
| ready_cnt_o | output | clog2(DEPTH+1) | Complete entries not yet claimed by a command |
| overflow_o | output | 1 | One-cycle pulse: a slice was dropped |
| underflow_o | output | 1 | One-cycle pulse: a command found no complete entry |

## Verification
The hardest state to reach is a dropped slice, where every slot is held and the next slice would open a fresh entry. The bench gets there by filling all DEPTH entries before issuing any command. It then offers a tagged slice, drains one entry, and refills the freed slot. The later bursts must show that the tagged slice is absent. A second hard case is an underflow that arrives while a partial entry exists. Each depth sweep leaves two slices open, lets a command find nothing complete, and then finishes the entry and drains it.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int unsigned BEAT_W_DEF = 72;
    localparam int unsigned BEATS_DEF  = 4;
    localparam int unsigned DEPTH_DEF  = 4;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_st_e;
endpackage

// File: rtl/wbuf_fill.sv
module wbuf_fill #(
    parameter int unsigned DEPTH = wbuf_pkg::DEPTH_DEF,
    parameter int unsigned BEATS = wbuf_pkg::BEATS_DEF,
    localparam int unsigned EW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_vld_i,
    input  logic          room_i,
    output logic          wr_en_o,
    output logic [EW-1:0] wr_ent_o,
    output logic [BW-1:0] wr_beat_o,
    output logic          open_o,
    output logic          complete_o,
    output logic          drop_o
);
    localparam logic [BW-1:0] BEAT_LAST = BW'(BEATS - 1);
    localparam logic [EW-1:0] ENT_LAST  = EW'(DEPTH - 1);

    typedef struct packed {
        logic [EW-1:0] ent;
        logic [BW-1:0] beat;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic     accept;

    always_comb begin
        st_d   = st_q;
        accept = frame_vld_i && ((st_q.beat != '0) || room_i);
        if (accept) begin
            if (st_q.beat == BEAT_LAST) begin
                st_d.beat = '0;
                st_d.ent  = (st_q.ent == ENT_LAST) ? '0 : st_q.ent + 1'b1;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o    = accept;
    assign wr_ent_o   = st_q.ent;
    assign wr_beat_o  = st_q.beat;
    assign open_o     = accept && (st_q.beat == '0);
    assign complete_o = accept && (st_q.beat == BEAT_LAST);
    assign drop_o     = frame_vld_i && !accept;
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int unsigned BEAT_W = wbuf_pkg::BEAT_W_DEF,
    parameter int unsigned DEPTH  = wbuf_pkg::DEPTH_DEF,
    parameter int unsigned BEATS  = wbuf_pkg::BEATS_DEF,
    localparam int unsigned EW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [EW-1:0]     w_ent_i,
    input  logic [BW-1:0]     w_beat_i,
    input  logic [BEAT_W-1:0] w_data_i,
    input  logic [EW-1:0]     r_ent_i,
    input  logic [BW-1:0]     r_beat_i,
    output logic [BEAT_W-1:0] r_data_o
);
    localparam int unsigned SLOTS = DEPTH * BEATS;

    logic [BEAT_W-1:0] mem_q [SLOTS];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[{w_ent_i, w_beat_i}] <= w_data_i;
    end

    assign r_data_o = mem_q[{r_ent_i, r_beat_i}];
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain #(
    parameter int unsigned DEPTH = wbuf_pkg::DEPTH_DEF,
    parameter int unsigned BEATS = wbuf_pkg::BEATS_DEF,
    localparam int unsigned EW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    output logic          start_o,
    output logic [EW-1:0] rd_ent_o,
    output logic [BW-1:0] rd_beat_o,
    output logic          vld_o,
    output logic          last_o
);
    import wbuf_pkg::*;

    localparam logic [BW-1:0] BEAT_LAST = BW'(BEATS - 1);
    localparam logic [EW-1:0] ENT_LAST  = EW'(DEPTH - 1);

    typedef struct packed {
        drain_st_e     st;
        logic [EW-1:0] ent;
        logic [BW-1:0] beat;
    } drain_t;

    drain_t st_d, st_q;
    logic   start;

    always_comb begin
        st_d  = st_q;
        start = (st_q.st == DR_IDLE) && go_i;
        if (start) begin
            st_d.st   = DR_SEND;
            st_d.beat = '0;
        end else if (st_q.st == DR_SEND) begin
            if (st_q.beat == BEAT_LAST) begin
                st_d.st   = DR_IDLE;
                st_d.beat = '0;
                st_d.ent  = (st_q.ent == ENT_LAST) ? '0 : st_q.ent + 1'b1;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: DR_IDLE, ent: '0, beat: '0};
        else        st_q <= st_d;
    end

    assign start_o   = start;
    assign rd_ent_o  = st_q.ent;
    assign rd_beat_o = st_q.beat;
    assign vld_o     = (st_q.st == DR_SEND);
    assign last_o    = (st_q.st == DR_SEND) && (st_q.beat == BEAT_LAST);
endmodule

// File: rtl/wbuf_burst_buffer.sv
module wbuf_burst_buffer #(
    parameter int unsigned BEAT_W = wbuf_pkg::BEAT_W_DEF,
    parameter int unsigned DEPTH  = wbuf_pkg::DEPTH_DEF,
    parameter int unsigned BEATS  = wbuf_pkg::BEATS_DEF,
    localparam int unsigned EW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_frame_vld_i,
    input  logic [BEAT_W-1:0] wr_frame_data_i,
    input  logic              wr_cmd_i,
    output logic              burst_vld_o,
    output logic              burst_last_o,
    output logic [BEAT_W-1:0] burst_data_o,
    output logic [CW-1:0]     ready_cnt_o,
    output logic              overflow_o,
    output logic              underflow_o
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;   // complete, unclaimed entries
        logic [CW-1:0] pend;  // claimed entries waiting for the drain side
        logic [CW-1:0] used;  // slots holding any data
        logic          ovf;
        logic          udf;
    } occ_t;

    occ_t occ_d, occ_q;

    logic          wr_en, open_ent, complete, drop;
    logic [EW-1:0] wr_ent, rd_ent;
    logic [BW-1:0] wr_beat, rd_beat;
    logic          start, done, cmd_ok;

    wbuf_fill #(.DEPTH(DEPTH), .BEATS(BEATS)) fill_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_vld_i (wr_frame_vld_i),
        .room_i      (occ_q.used != DEPTH_C),
        .wr_en_o     (wr_en),
        .wr_ent_o    (wr_ent),
        .wr_beat_o   (wr_beat),
        .open_o      (open_ent),
        .complete_o  (complete),
        .drop_o      (drop)
    );

    wbuf_store #(.BEAT_W(BEAT_W), .DEPTH(DEPTH), .BEATS(BEATS)) store_i (
        .clk      (clk),
        .we_i     (wr_en),
        .w_ent_i  (wr_ent),
        .w_beat_i (wr_beat),
        .w_data_i (wr_frame_data_i),
        .r_ent_i  (rd_ent),
        .r_beat_i (rd_beat),
        .r_data_o (burst_data_o)
    );

    wbuf_drain #(.DEPTH(DEPTH), .BEATS(BEATS)) drain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (occ_q.pend != '0),
        .start_o   (start),
        .rd_ent_o  (rd_ent),
        .rd_beat_o (rd_beat),
        .vld_o     (burst_vld_o),
        .last_o    (burst_last_o)
    );

    assign done = burst_last_o;

    always_comb begin
        occ_d      = occ_q;
        cmd_ok     = wr_cmd_i && (occ_q.cnt != '0);
        occ_d.cnt  = occ_q.cnt  + CW'(complete) - CW'(cmd_ok);
        occ_d.pend = occ_q.pend + CW'(cmd_ok)   - CW'(start);
        occ_d.used = occ_q.used + CW'(open_ent) - CW'(done);
        occ_d.ovf  = drop;
        occ_d.udf  = wr_cmd_i && !cmd_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign ready_cnt_o = occ_q.cnt;
    assign overflow_o  = occ_q.ovf;
    assign underflow_o = occ_q.udf;

    // R3
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last_o |-> burst_vld_o);
    // R3
    beats_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_vld_o && !burst_last_o) |=> burst_vld_o);
    // R7
    gap_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last_o |=> !burst_vld_o);
    // R5
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> ($past(occ_q.used) == DEPTH_C));
    // R4
    underflow_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> ($past(occ_q.cnt) == '0));
    // R4
    burst_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_vld_o) |-> ($past(occ_q.pend) != '0));
    // R2
    accounting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occ_q.cnt} + {1'b0, occ_q.pend}) <= {1'b0, occ_q.used});
endmodule

// File: tb/wbuf_burst_buffer_tb_top.sv
module wbuf_burst_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int BEATS = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_frame_vld_i = 1'b0;
    logic [71:0] wr_frame_data_i = '0;
    logic        wr_cmd_i = 1'b0;
    logic        burst_vld_o, burst_last_o, overflow_o, underflow_o;
    logic [71:0] burst_data_o;
    logic [CW-1:0] ready_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_burst_buffer dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_frame_vld_i  (wr_frame_vld_i),
        .wr_frame_data_i (wr_frame_data_i),
        .wr_cmd_i        (wr_cmd_i),
        .burst_vld_o     (burst_vld_o),
        .burst_last_o    (burst_last_o),
        .burst_data_o    (burst_data_o),
        .ready_cnt_o     (ready_cnt_o),
        .overflow_o      (overflow_o),
        .underflow_o     (underflow_o)
    );

    function automatic logic [71:0] pat(input int e, input int b);
        return {8'h5A, 32'(e), 32'(b)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_frame_vld_i = 1'b0;
        wr_cmd_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(burst_vld_o == 1'b0, "R1", "burst_vld", 72'(burst_vld_o), 72'(0));
        chk(ready_cnt_o == '0, "R1", "ready_cnt", 72'(ready_cnt_o), 72'(0));
        chk(!overflow_o && !underflow_o, "R1", "flags",
            72'({overflow_o, underflow_o}), 72'(0));
    endtask

    task automatic frame(input logic [71:0] d, input bit exp_ovf,
                         input int exp_cnt, input string req);
        wr_frame_vld_i = 1'b1;
        wr_frame_data_i = d;
        @(negedge clk);
        wr_frame_vld_i = 1'b0;
        chk(overflow_o == exp_ovf, req, "overflow", 72'(overflow_o), 72'(exp_ovf));
        chk(int'(ready_cnt_o) == exp_cnt, req, "ready_cnt",
            72'(ready_cnt_o), 72'(exp_cnt));
    endtask

    task automatic watch_burst(input int e, input string req);
        for (int b = 0; b < BEATS; b++) begin
            chk(burst_vld_o == 1'b1, req, "beat valid", 72'(burst_vld_o), 72'(1));
            chk(burst_data_o == pat(e, b), req, "beat data", burst_data_o, pat(e, b));
            chk(burst_last_o == (b == BEATS-1), req, "last marker",
                72'(burst_last_o), 72'(b == BEATS-1));
            @(negedge clk);
        end
    endtask

    task automatic cmd_drain(input int e, input int exp_cnt_after);
        wr_cmd_i = 1'b1;
        @(negedge clk);
        wr_cmd_i = 1'b0;
        chk(underflow_o == 1'b0, "R3", "underflow", 72'(underflow_o), 72'(0));
        chk(burst_vld_o == 1'b0, "R3", "early valid", 72'(burst_vld_o), 72'(0));
        chk(int'(ready_cnt_o) == exp_cnt_after, "R3", "ready_cnt after cmd",
            72'(ready_cnt_o), 72'(exp_cnt_after));
        @(negedge clk);
        watch_burst(e, "R6");
        chk(burst_vld_o == 1'b0, "R3", "valid after burst", 72'(burst_vld_o), 72'(0));
    endtask

    task automatic cmd_empty();
        wr_cmd_i = 1'b1;
        @(negedge clk);
        wr_cmd_i = 1'b0;
        chk(underflow_o == 1'b1, "R4", "underflow pulse", 72'(underflow_o), 72'(1));
        @(negedge clk);
        chk(underflow_o == 1'b0, "R4", "underflow clears", 72'(underflow_o), 72'(0));
        chk(burst_vld_o == 1'b0, "R4", "no burst", 72'(burst_vld_o), 72'(0));
        @(negedge clk);
        chk(burst_vld_o == 1'b0, "R4", "no burst later", 72'(burst_vld_o), 72'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Sweep over fill depth: R2, R3, R4, R6
        for (int n = 1; n <= DEPTH; n++) begin
            do_reset();
            for (int e = 0; e < n; e++)
                for (int b = 0; b < BEATS; b++)
                    frame(pat(e, b), 1'b0, e + ((b == BEATS-1) ? 1 : 0), "R2");
            if (n < DEPTH) begin
                frame(pat(n, 0), 1'b0, n, "R2");
                frame(pat(n, 1), 1'b0, n, "R2");
            end
            for (int e = 0; e < n; e++) cmd_drain(e, n - 1 - e);
            cmd_empty();
            if (n < DEPTH) begin
                frame(pat(n, 2), 1'b0, 0, "R4");
                frame(pat(n, 3), 1'b0, 1, "R4");
                cmd_drain(n, 0);
            end
        end

        // Overflow and slot reuse: R5, R8
        do_reset();
        for (int e = 0; e < DEPTH; e++)
            for (int b = 0; b < BEATS; b++)
                frame(pat(e, b), 1'b0, e + ((b == BEATS-1) ? 1 : 0), "R2");
        frame(pat(99, 0), 1'b1, DEPTH, "R5");
        @(negedge clk);
        chk(overflow_o == 1'b0, "R5", "overflow clears", 72'(overflow_o), 72'(0));
        cmd_drain(0, DEPTH - 1);
        for (int b = 0; b < BEATS; b++)
            frame(pat(DEPTH, b), 1'b0, (b == BEATS-1) ? DEPTH : DEPTH - 1, "R8");
        for (int e = 1; e <= DEPTH; e++) cmd_drain(e, DEPTH - e);

        // Queued commands during a burst: R7
        do_reset();
        for (int e = 0; e < 2; e++)
            for (int b = 0; b < BEATS; b++)
                frame(pat(e, b), 1'b0, e + ((b == BEATS-1) ? 1 : 0), "R2");
        wr_cmd_i = 1'b1;
        @(negedge clk);
        chk(int'(ready_cnt_o) == 1, "R7", "ready_cnt first cmd", 72'(ready_cnt_o), 72'(1));
        @(negedge clk);
        wr_cmd_i = 1'b0;
        chk(int'(ready_cnt_o) == 0, "R7", "ready_cnt second cmd", 72'(ready_cnt_o), 72'(0));
        watch_burst(0, "R7");
        chk(burst_vld_o == 1'b0, "R7", "idle gap", 72'(burst_vld_o), 72'(0));
        @(negedge clk);
        watch_burst(1, "R7");
        chk(burst_vld_o == 1'b0, "R7", "idle after", 72'(burst_vld_o), 72'(0));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule